// File: doc/BRIEF.md
# Interrupt Moderation Timer

This block sits between a network controller's event sources and its interrupt cause register. Each cycle it takes a vector of event cause bits. When moderation is off, the vector passes straight through. When moderation is on, the first event after a quiet period is posted at once. Events that arrive while the moderation timer runs are collected in a pending register and posted together when the timer expires.

The moderation delay is chosen when a burst is posted. It is the smallest nonzero candidate among three: a transmit delay, a receive delay and a throttle interval. A candidate counts only when the causes in that burst make it relevant. The timer counts in 256 ns ticks, which a prescaler derives from the core clock. Four 16-bit registers hold the settings and are reached through a simple write/read port. Each posted burst leaves the block as a one-cycle valid strobe with its cause vector, meant for a downstream register that ORs the bits in.

Top module: `imod_top`

## Requirements
- R1: While `mod_en` is low, `irq_valid` equals the OR of `ev_cause`, and `irq_cause` equals `ev_cause` in the same cycle.
- R2: A cycle with `mod_en` low clears the pending causes and stops the timer. The next cause that arrives with `mod_en` high is posted at once.
- R3: With moderation on and the timer idle, a nonzero cause vector is posted in the same cycle. The timer is then armed with the computed delay.
- R4: While the timer runs and has not expired, incoming causes are ORed into the pending register and `irq_valid` stays low.
- R5: A timer armed with delay D ticks expires exactly D*TICK_DIV cycles after the arming cycle. If causes are pending at that point, they are posted and the timer is rearmed from them.
- R6: At an expiry with nothing pending and no new cause, nothing is posted and the timer goes idle. A later cause is then posted at once.
- R7: The delay is the minimum of the applicable nonzero candidates. If no candidate applies, the timer is not armed, and the next cause is posted at once.
- R8: The transmit candidate is 4 times the transmit delay register. It applies only when cause bit 0 (transmit done) or bit 1 (transmit queue empty) is in the posted burst.
- R9: The receive candidate is 4 times the receive delay register. It applies only when cause bit 7 (receive timer) is in the burst and the receive-enable register is nonzero.
- R10: The throttle register is always a candidate, taken directly in ticks.
- R11: Register select 0 is receive delay, 1 is receive enable, 2 is transmit delay and 3 is throttle. A write keeps the low 16 bits of `cfg_wdata`, and `cfg_rdata` returns them.
- R12: Reset clears all four registers, the pending causes and the timer.
- R13: A cause that arrives in the expiry cycle is merged into the vector posted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Moderation enable; low selects pass-through |
| ev_cause | input | CAUSE_W | Event cause bits for this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register select |
| cfg_wdata | input | 32 | Write data; only the low 16 bits are kept |
| cfg_rdata | output | 16 | Contents of the selected register |
| irq_valid | output | 1 | One-cycle strobe for a posted cause vector |
| irq_cause | output | CAUSE_W | Posted cause vector |

## Verification
Immediate posts and pass-through are combinational, so they are sampled in the same cycle the cause is driven, one time unit after the falling edge. An expiry is due exactly D*TICK_DIV cycles after the arming cycle. The bench counts cycles from the post, expects `irq_valid` low in every cycle before that point, and expects the merged vector in that exact cycle. Register readback is combinational and is sampled right after the write cycle has completed.

// File: rtl/imod_pkg.sv
package imod_pkg;
  localparam int REG_W  = 16;
  localparam int DLY_W  = REG_W + 2;
  localparam int REG_N  = 4;
  localparam int SEL_RXDLY = 0;
  localparam int SEL_RXEN  = 1;
  localparam int SEL_TXDLY = 2;
  localparam int SEL_THR   = 3;

  typedef logic [DLY_W-1:0] dly_t;

  // keep the smaller nonzero of two delays; zero means "unset"
  function automatic dly_t min_nz(input dly_t a, input dly_t b);
    if (a == '0) return b;
    if (b == '0) return a;
    return (a < b) ? a : b;
  endfunction

  function automatic dly_t pick_delay(input logic tx_hit, input logic rx_hit,
                                      input logic [REG_W-1:0] tx_dly,
                                      input logic [REG_W-1:0] rx_dly,
                                      input logic [REG_W-1:0] thr);
    dly_t d;
    d = dly_t'(thr);
    if (tx_hit) d = min_nz(d, dly_t'({tx_dly, 2'b00}));
    if (rx_hit) d = min_nz(d, dly_t'({rx_dly, 2'b00}));
    return d;
  endfunction
endpackage

// File: rtl/imod_cfg_regs.sv
module imod_cfg_regs
  import imod_pkg::*;
#(
  parameter int N = REG_N,
  localparam int SW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SW-1:0]    sel,
  input  logic [31:0]      wdata,
  output logic [N*REG_W-1:0] regs_flat,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] regs_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                       regs_q[i] <= '0;
      else if (we && sel == SW'(i))     regs_q[i] <= wdata[REG_W-1:0];
    end
    assign regs_flat[i*REG_W +: REG_W] = regs_q[i];
  end

  assign rdata = regs_q[sel];
endmodule

// File: rtl/imod_delay_sel.sv
module imod_delay_sel
  import imod_pkg::*;
#(
  parameter int CAUSE_W = 8,
  parameter int TXDONE_BIT = 0,
  parameter int TXEMPTY_BIT = 1,
  parameter int RXTMR_BIT = 7
) (
  input  logic [CAUSE_W-1:0]   causes,
  input  logic [REG_N*REG_W-1:0] regs_flat,
  output dly_t                 next_delay
);
  logic [REG_W-1:0] rx_dly, rx_en, tx_dly, thr;
  logic tx_hit, rx_hit;

  assign rx_dly = regs_flat[SEL_RXDLY*REG_W +: REG_W];
  assign rx_en  = regs_flat[SEL_RXEN*REG_W  +: REG_W];
  assign tx_dly = regs_flat[SEL_TXDLY*REG_W +: REG_W];
  assign thr    = regs_flat[SEL_THR*REG_W   +: REG_W];

  assign tx_hit = causes[TXDONE_BIT] | causes[TXEMPTY_BIT];
  assign rx_hit = causes[RXTMR_BIT] & (rx_en != '0);

  assign next_delay = pick_delay(tx_hit, rx_hit, tx_dly, rx_dly, thr);
endmodule

// File: rtl/imod_tick_timer.sv
module imod_tick_timer
  import imod_pkg::*;
#(
  parameter int TICK_DIV = 64,
  localparam int PC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic arm,
  input  dly_t load,
  output logic running,
  output logic expire
);
  logic [PC_W-1:0] pc_q;
  dly_t            cnt_q;
  logic            tick;

  assign tick    = running && (pc_q == PC_W'(TICK_DIV - 1));
  assign expire  = tick && (cnt_q == dly_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc_q    <= '0;
      cnt_q   <= '0;
    end else if (stop) begin
      running <= 1'b0;
      pc_q    <= '0;
    end else if (arm) begin
      running <= 1'b1;
      pc_q    <= '0;
      cnt_q   <= load;
    end else if (running) begin
      pc_q <= tick ? '0 : pc_q + 1'b1;
      if (tick) begin
        if (cnt_q == dly_t'(1)) running <= 1'b0;
        else                    cnt_q   <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/imod_top.sv
module imod_top
  import imod_pkg::*;
#(
  parameter int CAUSE_W = 8,
  parameter int TICK_DIV = 64,
  parameter int TXDONE_BIT = 0,
  parameter int TXEMPTY_BIT = 1,
  parameter int RXTMR_BIT = 7,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mod_en,
  input  logic [CAUSE_W-1:0] ev_cause,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic               irq_valid,
  output logic [CAUSE_W-1:0] irq_cause
);
  logic [REG_N*REG_W-1:0] regs_flat;
  logic [CAUSE_W-1:0]     pend_q, merged;
  dly_t                   next_delay;
  logic                   timer_run, expire_evt, post_evt, arm, stop;

  imod_cfg_regs #(.N(REG_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .regs_flat(regs_flat), .rdata(cfg_rdata)
  );

  assign merged   = pend_q | ev_cause;
  assign post_evt = mod_en && (merged != '0) && (!timer_run || expire_evt);

  imod_delay_sel #(
    .CAUSE_W(CAUSE_W), .TXDONE_BIT(TXDONE_BIT),
    .TXEMPTY_BIT(TXEMPTY_BIT), .RXTMR_BIT(RXTMR_BIT)
  ) u_dsel (
    .causes(merged), .regs_flat(regs_flat), .next_delay(next_delay)
  );

  assign arm  = post_evt && (next_delay != '0);
  assign stop = !mod_en || (post_evt && (next_delay == '0));

  imod_tick_timer #(.TICK_DIV(TICK_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .stop(stop), .arm(arm), .load(next_delay),
    .running(timer_run), .expire(expire_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !mod_en || post_evt) pend_q <= '0;
    else                               pend_q <= merged;
  end

  always_comb begin
    if (!mod_en) begin
      irq_valid = (ev_cause != '0);
      irq_cause = ev_cause;
    end else begin
      irq_valid = post_evt;
      irq_cause = post_evt ? merged : '0;
    end
  end
endmodule

module imod_checker
  import imod_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mod_en,
  input logic [CAUSE_W-1:0] ev_cause,
  input logic               irq_valid,
  input logic [CAUSE_W-1:0] irq_cause,
  input logic               timer_run,
  input logic               expire_evt,
  input logic               post_evt,
  input dly_t               next_delay
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (irq_valid == (ev_cause != '0)) && (irq_cause == ev_cause));

  assert_disable_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !timer_run);

  assert_post_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && next_delay != '0) |=> timer_run);

  assert_quiet_while_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && timer_run && !expire_evt) |-> !irq_valid);

  assert_idle_after_empty_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !post_evt) |=> !timer_run);

  assert_zero_delay_no_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && next_delay == '0) |=> !timer_run);

  assert_nonempty_post_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_cause != '0));
endmodule

bind imod_top imod_checker #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .ev_cause(ev_cause),
  .irq_valid(irq_valid), .irq_cause(irq_cause), .timer_run(timer_run),
  .expire_evt(expire_evt), .post_evt(post_evt), .next_delay(next_delay)
);

// File: tb/tb_imod_top.sv
module tb_imod_top;
  localparam int DIV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b1;
  logic [7:0]  ev_cause = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_cause;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  imod_top dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .ev_cause(ev_cause),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_valid(irq_valid), .irq_cause(irq_cause)
  );

  // {en, cause, exp_valid, exp_cause}; throttle = 100 ticks during the walk
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 8'h01, 1'b1, 8'h01},  // R3 idle -> immediate post
    {1'b1, 8'h02, 1'b0, 8'h00},  // R4 merged while running
    {1'b1, 8'h80, 1'b0, 8'h00},  // R4
    {1'b0, 8'h05, 1'b1, 8'h05},  // R1 pass-through
    {1'b1, 8'h04, 1'b1, 8'h04},  // R2 after disable: immediate
    {1'b1, 8'h00, 1'b0, 8'h00},  // R4 nothing
    {1'b1, 8'h10, 1'b0, 8'h00},  // R4 running again
    {1'b0, 8'h00, 1'b0, 8'h00}   // R1 zero pass-through
  };

  task automatic check(input string tag, input logic v_act, input logic [7:0] c_act,
                       input logic v_exp, input logic [7:0] c_exp);
    total++;
    if (v_act !== v_exp || c_act !== c_exp) begin
      bad++;
      $display("FAIL %s: valid/cause act=%0b/%h exp=%0b/%h", tag, v_act, c_act, v_exp, c_exp);
    end
  endtask

  task automatic drive(input logic en, input logic [7:0] c);
    @(negedge clk);
    mod_en = en;
    ev_cause = c;
    #1;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    ev_cause = '0;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] s, input logic [15:0] exp);
    cfg_sel = s;
    #1;
    total++;
    if (cfg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: rdata[%0d] act=%h exp=%h", tag, s, cfg_rdata, exp);
    end
  endtask

  task automatic set_all(input logic [15:0] rxd, input logic [15:0] rxe,
                         input logic [15:0] txd, input logic [15:0] thr);
    wreg(2'd0, {16'hFFFF, rxd});
    wreg(2'd1, {16'hFFFF, rxe});
    wreg(2'd2, {16'hFFFF, txd});
    wreg(2'd3, {16'hFFFF, thr});
    drive(1'b0, 8'h00);  // flush pending and timer
  endtask

  // runs d cycles after a post; 'pend' enters on the first, 'extra' on the last
  task automatic wait_expiry(input int d, input logic [7:0] pend, input logic [7:0] extra,
                             input logic ev, input logic [7:0] ec, input string tag);
    int early = 0;
    for (int k = 1; k <= d; k++) begin
      drive(1'b1, (k == 1) ? pend : ((k == d) ? extra : 8'h00));
      if (k < d && irq_valid) early++;
      if (k == d) check(tag, irq_valid, irq_cause, ev, ec);
    end
    total++;
    if (early != 0) begin
      bad++;
      $display("FAIL %s: early posts act=%0d exp=0", tag, early);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rchk("R12", 2'd0, 16'h0); rchk("R12", 2'd1, 16'h0);
    rchk("R12", 2'd2, 16'h0); rchk("R12", 2'd3, 16'h0);

    // R11 low 16 bits kept, select map
    wreg(2'd2, 32'h1234ABCD);
    rchk("R11", 2'd2, 16'hABCD);
    rchk("R11", 2'd0, 16'h0000);

    // table walk, throttle 100 ticks
    set_all(16'd0, 16'd0, 16'd0, 16'd100);
    foreach (VEC[i]) begin
      drive(VEC[i][17], VEC[i][16:9]);
      check($sformatf("R1/R2/R3/R4 row%0d", i), irq_valid, irq_cause, VEC[i][8], VEC[i][7:0]);
    end

    // R5 / R10: throttle 2 ticks, expiry posts pending exactly 128 cycles later
    set_all(16'd0, 16'd0, 16'd0, 16'd2);
    drive(1'b1, 8'h02);
    check("R3", irq_valid, irq_cause, 1'b1, 8'h02);
    wait_expiry(2*DIV, 8'h08, 8'h00, 1'b1, 8'h08, "R5 R10");
    // R6: rearmed, expires empty, then idle
    wait_expiry(2*DIV, 8'h00, 8'h00, 1'b0, 8'h00, "R6");
    drive(1'b1, 8'h20);
    check("R6", irq_valid, irq_cause, 1'b1, 8'h20);

    // R8: tx delay 1 -> 4 ticks beats throttle 10
    set_all(16'd0, 16'd0, 16'd1, 16'd10);
    drive(1'b1, 8'h01);
    check("R8", irq_valid, irq_cause, 1'b1, 8'h01);
    wait_expiry(4*DIV, 8'h40, 8'h00, 1'b1, 8'h40, "R8 R7");

    // R9: rx enable zero -> throttle 10 applies
    set_all(16'd1, 16'd0, 16'd0, 16'd10);
    drive(1'b1, 8'h80);
    check("R9", irq_valid, irq_cause, 1'b1, 8'h80);
    wait_expiry(10*DIV, 8'h40, 8'h00, 1'b1, 8'h40, "R9 off R10");

    // R9: rx enable nonzero -> 4 ticks
    set_all(16'd1, 16'd5, 16'd0, 16'd10);
    drive(1'b1, 8'h80);
    check("R9", irq_valid, irq_cause, 1'b1, 8'h80);
    wait_expiry(4*DIV, 8'h40, 8'h00, 1'b1, 8'h40, "R9 on");

    // R7: all zero -> never armed
    set_all(16'd0, 16'd0, 16'd0, 16'd0);
    drive(1'b1, 8'h01);
    check("R7", irq_valid, irq_cause, 1'b1, 8'h01);
    drive(1'b1, 8'h02);
    check("R7", irq_valid, irq_cause, 1'b1, 8'h02);

    // R8: tx delay ignored without a tx cause
    set_all(16'd0, 16'd0, 16'd1, 16'd0);
    drive(1'b1, 8'h80);
    check("R8", irq_valid, irq_cause, 1'b1, 8'h80);
    drive(1'b1, 8'h40);
    check("R8", irq_valid, irq_cause, 1'b1, 8'h40);

    // R13: cause arriving in expiry cycle merged
    set_all(16'd0, 16'd0, 16'd0, 16'd1);
    drive(1'b1, 8'h01);
    check("R13", irq_valid, irq_cause, 1'b1, 8'h01);
    wait_expiry(DIV, 8'h02, 8'h04, 1'b1, 8'h06, "R13");

    // R12: reset mid-run clears timer, pending and registers
    set_all(16'd0, 16'd0, 16'd0, 16'd200);
    drive(1'b1, 8'h01);
    drive(1'b1, 8'h02);
    @(negedge clk); rst_n = 1'b0; ev_cause = '0;
    @(negedge clk); rst_n = 1'b1;
    rchk("R12", 2'd3, 16'h0);
    drive(1'b1, 8'h10);
    check("R12", irq_valid, irq_cause, 1'b1, 8'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule